// File: doc/BRIEF.md
# Sine synthesizer with phase-accumulator PWM output

The block produces a sine wave of programmable frequency as an edge-aligned pulse-width modulated signal. A free-running PWM counter defines the period. Each time it wraps, a phase accumulator advances by a tuning word. The top bits of the accumulator select an entry of a sine table that is built into the block. That entry becomes the duty value of a later PWM period. After an external analog low-pass filter, the duty sequence forms the sine.

Since one accumulator step occurs per PWM period, the step rate is the clock rate divided by the number of counter states. The output frequency is the tuning word times that step rate divided by two to the number of active accumulator bits. The most significant active accumulator bit is brought out as a square wave at the synthesized frequency. A rising edge on the sync input restarts the phase at zero, which lets a system align the sine to a reference edge. A parameter selects between a full-cycle table and a quarter-cycle table. The quarter-cycle table rebuilds the rest of the wave by mirroring the index and negating the amplitude about mid-scale.

Top module: `dds_sine_pwm`

## Requirements
- R1: While reset is asserted, pwm_o, ovf_o and square_o are low, and the accumulator, the counter, the shadow register and the compare register are zero. The first full PWM period after reset therefore has pwm_o low throughout.
- R2: The PWM counter runs through 2^CNT_W states. ovf_o is high for exactly one clock, during the final count (all ones), once every 2^CNT_W clocks.
- R3: Within a period, pwm_o is high for counts 0 up to compare−1 and low from count compare onward. A compare value of 0 gives a period that is low throughout. pwm_o is never high during the final count.
- R4: In the clock edge that ends an overflow cycle, the accumulator becomes (accumulator + tune_i) mod 2^ACT_W. tune_i bits at positions ACT_W and above have no effect on any output.
- R5: tune_i is used only in the overflow cycle. Changes to tune_i during other cycles of a period do not alter square_o, pwm_o or the phase that the next step produces.
- R6: square_o equals accumulator bit ACT_W−1. It changes only in the clock edge that ends an overflow cycle.
- R7: The table address is the top ADDR_W accumulator bits. Let Q = 2^(ADDR_W−2), MID = 2^(CNT_W−1) and f(x) = ((MID−1)·(2Qx − x²)) div Q². For an address with quadrant k (the top two address bits) and low part l, take x = l when k is even and x = Q−1−l when k is odd, and v = MID + f(x). The sample is v for k < 2 and 2·MID − v for k ≥ 2.
- R8: The duty value of the period that begins after an overflow equals the table sample at the phase held during that overflow cycle, before the step. The compare value changes only at the end of an overflow cycle.
- R9: A rising edge of sync_i makes the next step load zero into the accumulator instead of adding tune_i. A rising edge seen in the overflow cycle itself takes effect in that step. Holding sync_i high causes only one restart.
- R10: The quarter-table and full-table variants (QUARTER = 1 and 0) give identical outputs for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tune_i | input | ACC_W | Frequency tuning word; only the low ACT_W bits are used |
| sync_i | input | 1 | Phase restart request; acts on its rising edge |
| pwm_o | output | 1 | Edge-aligned PWM output |
| square_o | output | 1 | Square wave from the top active accumulator bit |
| ovf_o | output | 1 | High during the final counter state of each period |

## Verification
The bench builds the block with CNT_W = 4, ACC_W = 12, ACT_W = 10 and ADDR_W = 6, which gives 16-clock PWM periods and a 64-entry sine cycle. With these values, a tuning word of 16 walks every table address in 64 steps. A tuning word of 1 wraps the whole accumulator in 1024 steps, and a tuning word with its unused top bits set shows that those bits are ignored. Both table variants run side by side on the same stimulus. Every clock, the bench compares pwm_o, square_o and ovf_o with a model derived from the formulas above. The stimulus includes changes to tune_i in the middle of a period, sync edges in different cycles, and sync held high.

// File: rtl/dds_sine_pkg.sv
package dds_sine_pkg;

    // One quarter of the wave at quarter index x, offset by mid-scale.
    function automatic int quarter_amp(input int x, input int addr_w, input int amp_w);
        int qlen;
        int mid;
        int half;
        qlen = 1 << (addr_w - 2);
        mid  = 1 << (amp_w - 1);
        half = mid - 1;
        return mid + (half * (2 * qlen * x - x * x)) / (qlen * qlen);
    endfunction

    // Full-cycle sample at table index idx, built from the quarter shape.
    function automatic int full_amp(input int idx, input int addr_w, input int amp_w);
        int qlen;
        int mid;
        int quad;
        int low;
        int x;
        int v;
        qlen = 1 << (addr_w - 2);
        mid  = 1 << (amp_w - 1);
        quad = idx / qlen;
        low  = idx % qlen;
        x    = ((quad % 2) == 1) ? (qlen - 1 - low) : low;
        v    = quarter_amp(x, addr_w, amp_w);
        return (quad >= 2) ? (2 * mid - v) : v;
    endfunction

endpackage

// File: rtl/dds_pwm_timer.sv
module dds_pwm_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] duty_i,
    output logic             ovf_o,
    output logic             pwm_o,
    output logic [CNT_W-1:0] cmp_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] cmp;
    } tmr_t;

    tmr_t s_d, s_q;
    logic wrap;

    always_comb begin
        s_d        = s_q;
        wrap       = (s_q.cnt == CNT_LAST);
        s_d.cnt    = s_q.cnt + 1'b1;
        // shadow follows the table sample; compare takes it only at wrap
        s_d.shadow = duty_i;
        if (wrap) begin
            s_d.cmp = s_q.shadow;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ovf_o = wrap;
    assign pwm_o = (s_q.cnt < s_q.cmp);
    assign cmp_o = s_q.cmp;
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W = 24,
    parameter int ACT_W = 20
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             sync_i,
    input  logic [ACC_W-1:0] tune_i,
    output logic [ACT_W-1:0] phase_o
);
    localparam logic [ACC_W-1:0] ACT_MASK = ACC_W'((longint'(1) << ACT_W) - 1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             sync_prev;
        logic             pend;
    } ph_t;

    ph_t  s_d, s_q;
    logic rise;

    always_comb begin
        s_d           = s_q;
        rise          = sync_i & ~s_q.sync_prev;
        s_d.sync_prev = sync_i;
        s_d.pend      = s_q.pend | rise;
        if (step_i) begin
            if (s_q.pend | rise) begin
                s_d.acc = '0;
            end else begin
                s_d.acc = (s_q.acc + tune_i) & ACT_MASK;
            end
            s_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.acc[ACT_W-1:0];
endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut
    import dds_sine_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int AMP_W   = 8,
    parameter bit QUARTER = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [AMP_W-1:0]  sample_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int QA_W  = ADDR_W - 2;
    localparam int QLEN  = 1 << QA_W;

    if (QUARTER) begin : g_quarter
        logic [AMP_W-1:0] rom [QLEN];
        logic [1:0]       quad;
        logic [QA_W-1:0]  low;
        logic [QA_W-1:0]  idx;
        logic [AMP_W-1:0] v;

        for (genvar g = 0; g < QLEN; g++) begin : g_ent
            assign rom[g] = AMP_W'(quarter_amp(g, ADDR_W, AMP_W));
        end

        always_comb begin
            quad     = addr_i[ADDR_W-1:ADDR_W-2];
            low      = addr_i[QA_W-1:0];
            idx      = quad[0] ? ~low : low;
            v        = rom[idx];
            sample_o = quad[1] ? (AMP_W'(0) - v) : v;
        end
    end else begin : g_full
        logic [AMP_W-1:0] rom [DEPTH];

        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            assign rom[g] = AMP_W'(full_amp(g, ADDR_W, AMP_W));
        end

        assign sample_o = rom[addr_i];
    end
endmodule

// File: rtl/dds_sine_pwm.sv
module dds_sine_pwm #(
    parameter int CNT_W   = 8,
    parameter int ACC_W   = 24,
    parameter int ACT_W   = 20,
    parameter int ADDR_W  = 8,
    parameter bit QUARTER = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [ACC_W-1:0] tune_i,
    input  logic             sync_i,
    output logic             pwm_o,
    output logic             square_o,
    output logic             ovf_o
);
    localparam int AMP_W = CNT_W;

    logic [ACT_W-1:0]  phase_w;
    logic [ADDR_W-1:0] addr_w;
    logic [AMP_W-1:0]  sample_w;
    logic [CNT_W-1:0]  cmp_w;

    dds_pwm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .duty_i (sample_w),
        .ovf_o  (ovf_o),
        .pwm_o  (pwm_o),
        .cmp_o  (cmp_w)
    );

    dds_phase_acc #(.ACC_W(ACC_W), .ACT_W(ACT_W)) u_phase (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (ovf_o),
        .sync_i  (sync_i),
        .tune_i  (tune_i),
        .phase_o (phase_w)
    );

    assign addr_w = phase_w[ACT_W-1 -: ADDR_W];

    dds_sine_lut #(.ADDR_W(ADDR_W), .AMP_W(AMP_W), .QUARTER(QUARTER)) u_lut (
        .addr_i   (addr_w),
        .sample_o (sample_w)
    );

    assign square_o = phase_w[ACT_W-1];
endmodule

// File: rtl/dds_sine_pwm_chk.sv
module dds_sine_pwm_chk #(
    parameter int CNT_W = 8,
    parameter int ACT_W = 20
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             pwm_o,
    input logic             ovf_o,
    input logic             square_o,
    input logic [CNT_W-1:0] cmp_i,
    input logic [ACT_W-1:0] phase_i
);
    // R2
    ovf_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> !ovf_o);

    // R3
    pwm_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> !pwm_o);

    // R3
    pwm_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> (pwm_o == (cmp_i != '0)));

    // R8
    cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(ovf_o) |-> $stable(cmp_i));

    // R4
    acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(ovf_o) |-> $stable(phase_i));

    // R6
    square_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(ovf_o) |-> $stable(square_o));
endmodule

bind dds_sine_pwm dds_sine_pwm_chk #(.CNT_W(CNT_W), .ACT_W(ACT_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwm_o    (pwm_o),
    .ovf_o    (ovf_o),
    .square_o (square_o),
    .cmp_i    (cmp_w),
    .phase_i  (phase_w)
);

// File: tb/tb_dds_sine_pwm.sv
module tb_dds_sine_pwm;
    localparam int CW   = 4;
    localparam int AW   = 12;
    localparam int PW   = 10;
    localparam int TW   = 6;
    localparam int P    = 1 << CW;
    localparam int MASK = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync = 1'b0;
    logic [AW-1:0] tune = '0;
    logic          pwm, sq, ovf, pwm2, sq2, ovf2;

    int total = 0;
    int bad = 0;
    int acc_m = 0;
    int duty_m = 0;
    bit pend_m = 1'b0;
    bit prev_m = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dds_sine_pwm #(.CNT_W(CW), .ACC_W(AW), .ACT_W(PW), .ADDR_W(TW), .QUARTER(1'b1)) dut (
        .clk_i(clk), .rst_ni(rst_n), .tune_i(tune), .sync_i(sync),
        .pwm_o(pwm), .square_o(sq), .ovf_o(ovf));

    dds_sine_pwm #(.CNT_W(CW), .ACC_W(AW), .ACT_W(PW), .ADDR_W(TW), .QUARTER(1'b0)) dut_full (
        .clk_i(clk), .rst_ni(rst_n), .tune_i(tune), .sync_i(sync),
        .pwm_o(pwm2), .square_o(sq2), .ovf_o(ovf2));

    function automatic int ref_amp(input int i);
        int q, mid, quad, low, x, v;
        q    = 1 << (TW - 2);
        mid  = 1 << (CW - 1);
        quad = i / q;
        low  = i % q;
        x    = (quad % 2 == 1) ? (q - 1 - low) : low;
        v    = mid + ((mid - 1) * (2 * q * x - x * x)) / (q * q);
        return (quad >= 2) ? (2 * mid - v) : v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One PWM period; inputs change at the listed cycles (-1 = never).
    task automatic run_period(input string tag, input int tmid, input int tend,
                              input int son, input int soff);
        int hi = 0, ovf_n = 0, sq_err = 0, eq_err = 0;
        bit pwm_ok = 1'b1, ovf_ok = 1'b1;
        int nduty = duty_m;
        for (int c = 0; c < P; c++) begin
            if (c == 3 && tmid >= 0) tune = AW'(tmid);
            if (c == 10 && tend >= 0) tune = AW'(tend);
            if (c == son) sync = 1'b1;
            if (c == soff) sync = 1'b0;
            if (sync && !prev_m) pend_m = 1'b1;
            prev_m = sync;
            if (pwm) hi++;
            if (pwm != (c < duty_m)) pwm_ok = 1'b0;
            if (ovf) ovf_n++;
            if (ovf != (c == P - 1)) ovf_ok = 1'b0;
            if (sq != ((acc_m >> (PW - 1)) & 1)) sq_err++;
            if (pwm2 != pwm || sq2 != sq || ovf2 != ovf) eq_err++;
            if (c == P - 1) begin
                nduty = ref_amp(acc_m >> (PW - TW));
                if (pend_m) acc_m = 0;
                else acc_m = (acc_m + (int'(tune) & MASK)) & MASK;
                pend_m = 1'b0;
            end
            @(negedge clk);
        end
        chk(pwm_ok, tag, hi, duty_m);
        chk(ovf_ok, "R2", ovf_n, 1);
        chk(sq_err == 0, "R6", sq_err, 0);
        chk(eq_err == 0, "R10", eq_err, 0);
        duty_m = nduty;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(pwm == 1'b0, "R1", int'(pwm), 0);
        chk(ovf == 1'b0, "R1", int'(ovf), 0);
        chk(sq == 1'b0, "R1", int'(sq), 0);
        rst_n = 1'b1;
        run_period("R1", -1, -1, -1, -1);
        // R7: one table entry per step over the whole cycle
        tune = AW'(1 << (PW - TW));
        for (int k = 0; k < 70; k++) run_period("R7", -1, -1, -1, -1);
        // R4: smallest step, full accumulator wrap
        tune = AW'(1);
        for (int k = 0; k < 1100; k++) run_period("R4", -1, -1, -1, -1);
        // R4: upper tuning bits set must be ignored
        tune = 12'hC25;
        for (int k = 0; k < 200; k++) run_period("R4", -1, -1, -1, -1);
        // R5: changes away from the overflow cycle
        for (int k = 0; k < 20; k++) run_period("R5", 300 + k, 45 + 7 * k, -1, -1);
        // R9: sync pulse mid-period
        tune = AW'(123);
        for (int k = 0; k < 5; k++) run_period("R8", -1, -1, -1, -1);
        run_period("R9", -1, -1, 6, 7);
        chk(acc_m == 0, "R9", acc_m, 0);
        for (int k = 0; k < 5; k++) run_period("R9", -1, -1, -1, -1);
        // R9: rise in the overflow cycle
        run_period("R9", -1, -1, P - 1, -1);
        run_period("R9", -1, -1, -1, 0);
        for (int k = 0; k < 4; k++) run_period("R9", -1, -1, -1, -1);
        // R9: held high restarts only once
        run_period("R9", -1, -1, 2, -1);
        for (int k = 0; k < 6; k++) run_period("R9", -1, -1, -1, -1);
        run_period("R9", -1, -1, -1, 1);
        // R4: backward stepping with the largest active word
        tune = AW'(MASK);
        for (int k = 0; k < 300; k++) run_period("R8", -1, -1, -1, -1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule